// File: doc/BRIEF.md
# Hex/Decimal Digit Adder-Subtractor

This unit performs one step of digit-serial arithmetic for a calculator datapath. Each evaluation takes two 4-bit digits and a carry or borrow from the previous digit position. It returns one result digit and the carry or borrow for the next position. The arithmetic runs in plain binary (base 16) or in decimal (base 10). A sequencer outside the block walks a multi-digit number one nibble at a time and feeds the carry-out back as the next carry-in.

An operand router sits in front of the arithmetic. A 3-bit source code picks which two of four candidate digits enter the core: three register digits and a constant digit. The whole unit is combinational, so the result settles in the same cycle the inputs change.

When the function code is not one of the four arithmetic codes, the first routed operand passes through unchanged and the carry-out is held low.

Top module: `digit_alu`

## Requirements
- R1: Function codes are 4 for binary add, 5 for decimal add, 6 for binary subtract and 7 for decimal subtract.
- R2: Binary add returns (x + y + carry_in) mod 16, and carry_out is 1 exactly when that sum exceeds 15.
- R3: Decimal add, with both operands in 0 to 9, returns a digit in 0 to 9 equal to (x + y + carry_in) mod 10, and carry_out is 1 exactly when that sum is 10 or more.
- R4: Binary subtract returns (x - y - carry_in) mod 16, and carry_out is a borrow that is 1 exactly when the true difference is negative.
- R5: Decimal subtract, with both operands in 0 to 9, returns (x - y - carry_in) mod 10, and carry_out is a borrow that is 1 exactly when the true difference is negative.
- R6: Any non-negative difference, in either subtract mode, gives carry_out 0.
- R7: The source code selects the pair (first, second) as follows. 0 selects (a, b), 1 selects (a, c), 2 selects (a, k), 3 selects (c, k), 4 selects (b, c), and 5 to 7 select (a, b).
- R8: Function codes 0 to 3 drive the first routed operand to result unchanged and hold carry_out at 0, whatever carry_in is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | 3 | Arithmetic function code |
| src_sel | input | 3 | Operand pair source code |
| carry_in | input | 1 | Carry (add) or borrow (subtract) from the lower digit |
| dig_a | input | 4 | Candidate digit a |
| dig_b | input | 4 | Candidate digit b |
| dig_c | input | 4 | Candidate digit c |
| dig_k | input | 4 | Constant candidate digit k |
| result | output | 4 | Result digit |
| carry_out | output | 1 | Carry (add) or borrow (subtract) to the next digit |

## Verification
The embedded checks re-derive the arithmetic identity of every mode whenever the inputs change. An add must satisfy result plus carry times the radix equal to the operand sum. A subtract must satisfy result plus subtrahend plus borrow-in equal to the minuend plus borrow times the radix. The checks also hold the decimal result inside 0 to 9, and hold the pass-through and the constant routing for the undefined codes. Some properties only the bench scenarios can show: that the encodings of the functions and sources match the requirements, that all five routing codes and the fallback pick the right digits, and that known corner values produce their exact results, such as a decimal borrow through zero giving 9 or 8.

// File: rtl/digit_alu_pkg.sv
package digit_alu_pkg;
    localparam int DIGIT_W = 4;
    localparam int SUM_W   = DIGIT_W + 1;

    // function codes
    localparam logic [2:0] FN_ADD_HEX = 3'd4;
    localparam logic [2:0] FN_ADD_DEC = 3'd5;
    localparam logic [2:0] FN_SUB_HEX = 3'd6;
    localparam logic [2:0] FN_SUB_DEC = 3'd7;

    // operand source codes
    localparam logic [2:0] SRC_A_B = 3'd0;
    localparam logic [2:0] SRC_A_C = 3'd1;
    localparam logic [2:0] SRC_A_K = 3'd2;
    localparam logic [2:0] SRC_C_K = 3'd3;
    localparam logic [2:0] SRC_B_C = 3'd4;

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
        logic               carry;
    } digit_res_t;
endpackage

// File: rtl/digit_src_mux.sv
module digit_src_mux
    import digit_alu_pkg::*;
(
    input  logic [2:0]         src_sel,
    input  logic [DIGIT_W-1:0] dig_a,
    input  logic [DIGIT_W-1:0] dig_b,
    input  logic [DIGIT_W-1:0] dig_c,
    input  logic [DIGIT_W-1:0] dig_k,
    output logic [DIGIT_W-1:0] first_d,
    output logic [DIGIT_W-1:0] second_d
);
    always_comb begin
        unique case (src_sel)
            SRC_A_C: begin first_d = dig_a; second_d = dig_c; end
            SRC_A_K: begin first_d = dig_a; second_d = dig_k; end
            SRC_C_K: begin first_d = dig_c; second_d = dig_k; end
            SRC_B_C: begin first_d = dig_b; second_d = dig_c; end
            default: begin first_d = dig_a; second_d = dig_b; end
        endcase
    end

    always_comb begin
        if (src_sel == SRC_A_K)
            AST_SRC_CONST_PAIR: assert (first_d == dig_a && second_d == dig_k); // R7
        if (src_sel > SRC_B_C)
            AST_SRC_FALLBACK: assert (first_d == dig_a && second_d == dig_b); // R7
    end
endmodule

// File: rtl/digit_addsub_core.sv
module digit_addsub_core
    import digit_alu_pkg::*;
(
    input  logic [2:0]         fn_code,
    input  logic [DIGIT_W-1:0] op_x,
    input  logic [DIGIT_W-1:0] op_y,
    input  logic               carry_in,
    output logic [DIGIT_W-1:0] digit_d,
    output logic               carry_d
);
    localparam logic [SUM_W-1:0] DEC_ADJ = SUM_W'(6);
    localparam logic [SUM_W-1:0] DEC_MAX = SUM_W'(9);

    logic [SUM_W-1:0] sum_d;
    logic [SUM_W-1:0] diff_d;
    logic [SUM_W-1:0] sum_adj_d;
    logic [SUM_W-1:0] diff_adj_d;
    digit_res_t       res_d;

    always_comb begin
        sum_d      = {1'b0, op_x} + {1'b0, op_y} + SUM_W'(carry_in);
        diff_d     = {1'b0, op_x} - {1'b0, op_y} - SUM_W'(carry_in);
        sum_adj_d  = sum_d + DEC_ADJ;
        diff_adj_d = diff_d - DEC_ADJ;
        res_d      = '{digit: op_x, carry: 1'b0};
        unique case (fn_code)
            FN_ADD_HEX: res_d = '{digit: sum_d[DIGIT_W-1:0], carry: sum_d[DIGIT_W]};
            FN_ADD_DEC: begin
                if (sum_d > DEC_MAX)
                    res_d = '{digit: sum_adj_d[DIGIT_W-1:0], carry: 1'b1};
                else
                    res_d = '{digit: sum_d[DIGIT_W-1:0], carry: 1'b0};
            end
            FN_SUB_HEX: res_d = '{digit: diff_d[DIGIT_W-1:0], carry: diff_d[DIGIT_W]};
            FN_SUB_DEC: begin
                if (diff_d[DIGIT_W])
                    res_d = '{digit: diff_adj_d[DIGIT_W-1:0], carry: 1'b1};
                else
                    res_d = '{digit: diff_d[DIGIT_W-1:0], carry: 1'b0};
            end
            default: ;
        endcase
        digit_d = res_d.digit;
        carry_d = res_d.carry;
    end

    // arithmetic identities, checked against the outputs
    always_comb begin
        if (fn_code == FN_ADD_HEX)
            AST_HEX_ADD_ID: assert (int'(digit_d) + 16 * int'(carry_d)
                                    == int'(op_x) + int'(op_y) + int'(carry_in)); // R2
        if (fn_code == FN_SUB_HEX)
            AST_HEX_SUB_ID: assert (int'(digit_d) + int'(op_y) + int'(carry_in)
                                    == int'(op_x) + 16 * int'(carry_d)); // R4
        if (fn_code == FN_ADD_DEC && op_x <= 4'd9 && op_y <= 4'd9)
            AST_DEC_ADD_ID: assert (digit_d <= 4'd9 && int'(digit_d) + 10 * int'(carry_d)
                                    == int'(op_x) + int'(op_y) + int'(carry_in)); // R3
        if (fn_code == FN_SUB_DEC && op_x <= 4'd9 && op_y <= 4'd9)
            AST_DEC_SUB_ID: assert (digit_d <= 4'd9 && int'(digit_d) + int'(op_y) + int'(carry_in)
                                    == int'(op_x) + 10 * int'(carry_d)); // R5
        if (fn_code[2] == 1'b0)
            AST_UNDEF_PASS: assert (digit_d == op_x && !carry_d); // R8
    end
endmodule

// File: rtl/digit_alu.sv
module digit_alu
    import digit_alu_pkg::*;
(
    input  logic [2:0] fn_code,
    input  logic [2:0] src_sel,
    input  logic       carry_in,
    input  logic [3:0] dig_a,
    input  logic [3:0] dig_b,
    input  logic [3:0] dig_c,
    input  logic [3:0] dig_k,
    output logic [3:0] result,
    output logic       carry_out
);
    logic [DIGIT_W-1:0] first_d;
    logic [DIGIT_W-1:0] second_d;

    digit_src_mux u_mux (
        .src_sel  (src_sel),
        .dig_a    (dig_a),
        .dig_b    (dig_b),
        .dig_c    (dig_c),
        .dig_k    (dig_k),
        .first_d  (first_d),
        .second_d (second_d)
    );

    digit_addsub_core u_core (
        .fn_code  (fn_code),
        .op_x     (first_d),
        .op_y     (second_d),
        .carry_in (carry_in),
        .digit_d  (result),
        .carry_d  (carry_out)
    );

    always_comb begin
        if (fn_code[2] && !fn_code[1] && (fn_code[0] || src_sel == SRC_A_K) && dig_a <= 4'd9 && dig_k <= 4'd9 && src_sel == SRC_A_K)
            AST_DEC_DIGIT_RANGE: assert (fn_code != FN_ADD_DEC || result <= 4'd9); // R3
    end
endmodule

// File: tb/tb_digit_alu.sv
module tb_digit_alu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0] fn_code = 3'd0;
    logic [2:0] src_sel = 3'd0;
    logic       carry_in = 1'b0;
    logic [3:0] dig_a = 4'd0, dig_b = 4'd0, dig_c = 4'd0, dig_k = 4'd0;
    logic [3:0] result;
    logic       carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    digit_alu dut (
        .fn_code(fn_code), .src_sel(src_sel), .carry_in(carry_in),
        .dig_a(dig_a), .dig_b(dig_b), .dig_c(dig_c), .dig_k(dig_k),
        .result(result), .carry_out(carry_out)
    );

    // {fn, a, k, cin, carry_exp, digit_exp}
    localparam int NV = 36;
    localparam logic [16:0] VEC [NV] = '{
        {3'd4,4'h0,4'h0,1'b0,1'b0,4'h0}, {3'd4,4'h0,4'h0,1'b1,1'b0,4'h1},
        {3'd4,4'h0,4'h9,1'b0,1'b0,4'h9}, {3'd4,4'h0,4'h9,1'b1,1'b0,4'hA},
        {3'd4,4'h9,4'h0,1'b0,1'b0,4'h9}, {3'd4,4'h9,4'h0,1'b1,1'b0,4'hA},
        {3'd4,4'h9,4'h9,1'b0,1'b1,4'h2}, {3'd4,4'h9,4'h9,1'b1,1'b1,4'h3},
        {3'd5,4'h0,4'h0,1'b0,1'b0,4'h0}, {3'd5,4'h0,4'h0,1'b1,1'b0,4'h1},
        {3'd5,4'h0,4'h9,1'b0,1'b0,4'h9}, {3'd5,4'h0,4'h9,1'b1,1'b1,4'h0},
        {3'd5,4'h9,4'h0,1'b0,1'b0,4'h9}, {3'd5,4'h9,4'h0,1'b1,1'b1,4'h0},
        {3'd5,4'h9,4'h9,1'b0,1'b1,4'h8}, {3'd5,4'h9,4'h9,1'b1,1'b1,4'h9},
        {3'd6,4'h0,4'h0,1'b0,1'b0,4'h0}, {3'd6,4'h0,4'h0,1'b1,1'b1,4'hF},
        {3'd6,4'h0,4'h9,1'b0,1'b1,4'h7}, {3'd6,4'h0,4'h9,1'b1,1'b1,4'h6},
        {3'd6,4'h9,4'h0,1'b0,1'b0,4'h9}, {3'd6,4'h9,4'h0,1'b1,1'b0,4'h8},
        {3'd6,4'h9,4'h9,1'b0,1'b0,4'h0}, {3'd6,4'h9,4'h9,1'b1,1'b1,4'hF},
        {3'd7,4'h0,4'h0,1'b0,1'b0,4'h0}, {3'd7,4'h0,4'h0,1'b1,1'b1,4'h9},
        {3'd7,4'h0,4'h9,1'b0,1'b1,4'h1}, {3'd7,4'h0,4'h9,1'b1,1'b1,4'h0},
        {3'd7,4'h9,4'h0,1'b0,1'b0,4'h9}, {3'd7,4'h9,4'h0,1'b1,1'b0,4'h8},
        {3'd7,4'h9,4'h9,1'b0,1'b0,4'h0}, {3'd7,4'h9,4'h9,1'b1,1'b1,4'h9},
        {3'd7,4'h0,4'h1,1'b0,1'b1,4'h9}, {3'd7,4'h0,4'h1,1'b1,1'b1,4'h8},
        {3'd7,4'h5,4'h5,1'b0,1'b0,4'h0}, {3'd7,4'h5,4'h5,1'b1,1'b1,4'h9}
    };

    task automatic check(input string req, input logic [3:0] y_exp, input logic c_exp);
        @(negedge clk);
        n_checks++;
        if (result !== y_exp || carry_out !== c_exp) begin
            n_errors++;
            $display("FAIL %s: fn=%0d sel=%0d a=%h b=%h c=%h k=%h cin=%0b got y=%h c=%0b expected y=%h c=%0b",
                     req, fn_code, src_sel, dig_a, dig_b, dig_c, dig_k, carry_in,
                     result, carry_out, y_exp, c_exp);
        end
    endtask

    task automatic drive(input logic [2:0] f, input logic [2:0] s, input logic ci,
                         input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] c, input logic [3:0] k);
        @(posedge clk);
        #1;
        fn_code = f; src_sel = s; carry_in = ci;
        dig_a = a; dig_b = b; dig_c = c; dig_k = k;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero inputs, pass-through of zero
        check("R8 reset", 4'h0, 1'b0);

        // table sweep over source code 2 (a with k)
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VEC[i][16:14])
                3'd4: tag = "R1 R2 hex add";
                3'd5: tag = "R1 R3 dec add";
                3'd6: tag = "R1 R4 R6 hex sub";
                default: tag = "R1 R5 R6 dec sub";
            endcase
            drive(VEC[i][16:14], 3'd2, VEC[i][5], VEC[i][13:10], 4'hE, 4'hD, VEC[i][9:6]);
            check(tag, VEC[i][3:0], VEC[i][4]);
        end

        // R7 routing, binary add with a=1 b=2 c=4 k=8
        drive(3'd4, 3'd0, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 sel0 a+b", 4'd3, 1'b0);
        drive(3'd4, 3'd1, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 sel1 a+c", 4'd5, 1'b0);
        drive(3'd4, 3'd2, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 sel2 a+k", 4'd9, 1'b0);
        drive(3'd4, 3'd3, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 sel3 c+k", 4'd12, 1'b0);
        drive(3'd4, 3'd4, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 sel4 b+c", 4'd6, 1'b0);
        for (int s = 5; s < 8; s++) begin
            drive(3'd4, 3'(s), 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 fallback a+b", 4'd3, 1'b0);
        end
        // R7 order matters for subtract: c - k and b - c
        drive(3'd6, 3'd3, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 R4 sel3 c-k", 4'hC, 1'b1);
        drive(3'd6, 3'd4, 1'b0, 4'd1, 4'd2, 4'd4, 4'd8); check("R7 R4 sel4 b-c", 4'hE, 1'b1);

        // R8 undefined codes pass the first operand, ignore carry_in
        for (int f = 0; f < 4; f++) begin
            drive(3'(f), 3'd3, 1'b1, 4'd1, 4'd2, 4'd7, 4'd8); check("R8 pass c", 4'd7, 1'b0);
        end
        drive(3'd2, 3'd4, 1'b1, 4'd1, 4'hB, 4'd7, 4'd8); check("R8 pass b", 4'hB, 1'b0);

        // corners
        drive(3'd4, 3'd0, 1'b1, 4'hF, 4'h0, 4'd0, 4'd0); check("R2 F+0+1 wrap", 4'h0, 1'b1);
        drive(3'd4, 3'd0, 1'b1, 4'hF, 4'hF, 4'd0, 4'd0); check("R2 F+F+1", 4'hF, 1'b1);
        drive(3'd5, 3'd0, 1'b1, 4'd5, 4'd4, 4'd0, 4'd0); check("R3 5+4+1 to ten", 4'd0, 1'b1);
        drive(3'd5, 3'd0, 1'b0, 4'd5, 4'd4, 4'd0, 4'd0); check("R3 5+4 stays", 4'd9, 1'b0);
        drive(3'd6, 3'd0, 1'b1, 4'h0, 4'hF, 4'd0, 4'd0); check("R4 0-F-1", 4'h0, 1'b1);
        drive(3'd7, 3'd0, 1'b1, 4'd3, 4'd2, 4'd0, 4'd0); check("R5 R6 3-2-1", 4'd0, 1'b0);
        drive(3'd7, 3'd0, 1'b0, 4'd2, 4'd7, 4'd0, 4'd0); check("R5 2-7", 4'd5, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule